// File: doc/BRIEF.md
# Edge-to-Pulse Encoder with Level Refresh

This block is the transmit-side logic of one channel in a pulse-coded isolation link. A slowly varying logic level cannot cross the link as a level. Each change of the level is therefore turned into a single-cycle pulse: a pulse on the set line means the input went high, and a pulse on the reset line means it went low. A bistable receiver on the far side rebuilds the level from these pulses.

A bistable receiver can drift out of step, for example after it powers up. It can also take a spurious hit. To bound how long such a mismatch lasts, the block can run a refresh mode. When the input has made no change for a programmable number of clock cycles, the block sends a pulse that carries the present level. It repeats that pulse for as long as the input holds still. An active-low enable selects refresh mode (low) or low-power mode (high). In low-power mode, pulses appear only on real input transitions. When refresh is switched on, the block sends one pulse at once so that the far side is brought back into agreement. The data input passes through a synchronizer first. The enable is taken as a synchronous control. All pins are plain level or pulse signals with no handshake, because a pulse is a one-shot event that the far side cannot hold off.

Top module: `pulse_link_encoder`

## Requirements
- R1: A low-to-high change of `data_in` produces `set_pulse` high for exactly one cycle. The pulse is seen SYNC_STAGES+1 clock edges after the first edge that samples the new level.
- R2: A high-to-low change of `data_in` produces `reset_pulse` high for exactly one cycle, with the same latency as R1.
- R3: `set_pulse` and `reset_pulse` are never high in the same cycle.
- R4: With `en_n` low and the input static, a pulse that carries the present synchronized level is sent REFRESH_CYCLES cycles after the previous pulse. Level 1 gives `set_pulse` and level 0 gives `reset_pulse`.
- R5: Refresh pulses repeat with a spacing of exactly REFRESH_CYCLES cycles while the input stays unchanged.
- R6: An input transition restarts the refresh interval. When a transition and a due refresh fall in the same cycle, only the transition pulse is sent.
- R7: With `en_n` high, no refresh pulse is ever sent. Only input transitions produce pulses.
- R8: When refresh becomes active, one pulse carrying the current synchronized level appears in the cycle after. Refresh becomes active when `en_n` goes from high to low, or when the block comes out of reset with `en_n` low. The interval then restarts from that pulse.
- R9: During reset both outputs are low. For SYNC_STAGES+1 cycles after reset is released, no pulse is sent, whatever the level of `data_in`. The edge history is loaded from the synchronized input, so a high input out of reset produces no edge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 1 | Logic level to convey; may be asynchronous |
| en_n | input | 1 | Active-low refresh enable, synchronous to clk |
| set_pulse | output | 1 | One-cycle pulse: the level went (or is) high |
| reset_pulse | output | 1 | One-cycle pulse: the level went (or is) low |

## Verification
The assertions check, on every cycle, that the two outputs are never high together. They also check that every detected edge yields its pulse on the next cycle, that low-power mode sends nothing except edge pulses, that turning refresh on yields a pulse, that the warm-up after reset stays quiet, and that the idle counter stays in range. Only the bench scenarios can show the exact refresh spacing. They also show that a transition restarts the interval, and that a transition coinciding with a due refresh gives a single pulse. The remaining cases are the level a refresh pulse carries and the behaviour after reset with a high input in both modes.

// File: rtl/plenc_pkg.sv
package plenc_pkg;

  typedef enum logic [1:0] {
    PULSE_NONE  = 2'd0,
    PULSE_SET   = 2'd1,
    PULSE_RESET = 2'd2
  } pulse_e;

  // Choose the pulse kind: an edge wins; a refresh carries the level.
  function automatic pulse_e pick_pulse(input logic rise, input logic fall,
                                        input logic refresh, input logic level);
    if (rise)              return PULSE_SET;
    else if (fall)         return PULSE_RESET;
    else if (refresh)      return level ? PULSE_SET : PULSE_RESET;
    else                   return PULSE_NONE;
  endfunction

endpackage

// File: rtl/plenc_sync.sv
module plenc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  initial begin
    assert (STAGES >= 2) else $error("plenc_sync needs at least two stages");
  end

endmodule

// File: rtl/plenc_edge.sv
module plenc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic primed,
  output logic rise,
  output logic fall
);

  localparam int WW = $clog2(STAGES + 1);

  logic [WW-1:0] warm;
  logic          prev;

  // Hold off edge detection until the synchronizer holds real samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm   <= '0;
      primed <= 1'b0;
    end else if (!primed) begin
      if (warm == WW'(STAGES)) primed <= 1'b1;
      else                     warm   <= warm + 1'b1;
    end
  end

  // History follows the synchronized level; during warm-up this seeds it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= level;
  end

  assign rise = primed &  level & ~prev;
  assign fall = primed & ~level &  prev;

  // Once armed, the detector stays armed until the next reset.
  assert_primed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    primed |=> primed);

  // An edge means the level differs from the one seen a cycle earlier.
  assert_edge_real_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rise || fall) |-> (level != $past(level)));

endmodule

// File: rtl/plenc_refresh.sv
module plenc_refresh #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,       // refresh mode active and detector armed
  input  logic restart,   // an edge pulse is being sent this cycle
  output logic fire
);

  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] idle;
  logic          run_q;
  logic          wake;
  logic          due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run;
  end

  assign wake = run & ~run_q;
  assign due  = (idle == CW'(CYCLES - 1));
  assign fire = run & ~restart & (wake | due);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     idle <= '0;
    else if (!run || restart || fire) idle <= '0;
    else                            idle <= idle + 1'b1;
  end

  assert_idle_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle <= CW'(CYCLES - 1));

  // An inactive refresh path keeps its counter cleared.
  assert_idle_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (idle == '0));

  initial begin
    assert (CYCLES >= 2) else $error("plenc_refresh needs CYCLES >= 2");
  end

endmodule

// File: rtl/pulse_link_encoder.sv
module pulse_link_encoder #(
  parameter int SYNC_STAGES    = 2,
  parameter int REFRESH_CYCLES = 35000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic data_in,
  input  logic en_n,
  output logic set_pulse,
  output logic reset_pulse
);

  import plenc_pkg::*;

  logic   level;
  logic   primed;
  logic   rise;
  logic   fall;
  logic   fire;
  logic   run;
  pulse_e kind;

  plenc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (data_in),
    .q     (level)
  );

  plenc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .level  (level),
    .primed (primed),
    .rise   (rise),
    .fall   (fall)
  );

  assign run = primed & ~en_n;

  plenc_refresh #(.CYCLES(REFRESH_CYCLES)) u_refresh (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (rise | fall),
    .fire    (fire)
  );

  assign kind = pick_pulse(rise, fall, fire, level);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_pulse   <= 1'b0;
      reset_pulse <= 1'b0;
    end else begin
      set_pulse   <= (kind == PULSE_SET);
      reset_pulse <= (kind == PULSE_RESET);
    end
  end

  assert_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_pulse && reset_pulse));

  assert_rise_to_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> set_pulse);

  assert_fall_to_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> reset_pulse);

  assert_lowpower_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n && !rise && !fall) |=> !(set_pulse || reset_pulse));

  assert_enable_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $fell(en_n)) |=> (set_pulse || reset_pulse));

  assert_warmup_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |=> !(set_pulse || reset_pulse));

endmodule

// File: tb/tb_pulse_link_encoder.sv
`timescale 1ns/1ps
module tb_pulse_link_encoder;

  localparam int STG = 2;
  localparam int N   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_in = 1'b0;
  logic en_n = 1'b1;
  logic set_pulse, reset_pulse;

  int checks = 0;
  int errors = 0;
  int win_sets = 0;
  int win_resets = 0;
  int both_hits = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pulse_link_encoder #(.SYNC_STAGES(STG), .REFRESH_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .en_n(en_n),
    .set_pulse(set_pulse), .reset_pulse(reset_pulse)
  );

  always @(negedge clk) begin
    if (set_pulse)   win_sets++;
    if (reset_pulse) win_resets++;
    if (set_pulse && reset_pulse) both_hits++;
  end

  typedef struct packed {
    logic d;
    logic en;
    int   hold;
    int   sets;
    int   resets;
  } vec_t;

  // Stimulus windows; state chains from one row to the next (N = 20).
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 10, 1, 0},  // R1 rise in low-power mode
    '{1'b0, 1'b1, 50, 0, 1},  // R2 fall, R7 no refresh for 50 cycles
    '{1'b0, 1'b0,  5, 0, 1},  // R8 enable on: immediate reset pulse (level 0)
    '{1'b0, 1'b0, 50, 0, 2},  // R4 R5 refresh at 20 and 40 after last pulse
    '{1'b1, 1'b0, 30, 2, 0},  // R6 edge restarts interval, refresh set follows
    '{1'b1, 1'b1, 40, 0, 0},  // R7 refresh off: static input silent
    '{1'b0, 1'b1, 10, 0, 1},  // R2 fall with refresh off
    '{1'b1, 1'b0, 10, 1, 1},  // R8 wake carries old level 0, then R1 rise
    '{1'b1, 1'b0, 30, 1, 0},  // R4 refresh set carries level 1
    '{1'b0, 1'b0,  3, 0, 1},  // R6 edge and due refresh coincide: one pulse
    '{1'b0, 1'b0, 20, 0, 1},  // R5 next refresh N cycles after the edge
    '{1'b1, 1'b0,  1, 0, 0},  // R1 fast toggling, pulses land in later window
    '{1'b0, 1'b0,  1, 0, 0},  // R2 fast toggling
    '{1'b1, 1'b0, 10, 2, 1}   // R3 back-to-back single-cycle pulses
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive inputs just after a falling edge, count pulses over `hold` edges.
  task automatic step(input logic d, input logic en, input int hold,
                      input int exp_s, input int exp_r, input string tag);
    data_in = d;
    en_n    = en;
    win_sets = 0;
    win_resets = 0;
    repeat (hold) @(negedge clk);
    #1;
    check({tag, " set count"}, win_sets, exp_s);
    check({tag, " reset count"}, win_resets, exp_r);
  endtask

  task automatic do_reset(input logic d, input logic en);
    @(negedge clk); #1;
    rst_n = 1'b0;
    data_in = d;
    en_n = en;
    repeat (3) @(negedge clk);
    #1;
    check("R9 set low in reset", int'(set_pulse), 0);
    check("R9 reset low in reset", int'(reset_pulse), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset with a high input and refresh on: quiet warm-up, then wake pulse.
    do_reset(1'b1, 1'b0);
    step(1'b1, 1'b0, STG + 1, 0, 0, "R9 warm-up quiet");
    step(1'b1, 1'b0, 1,       1, 0, "R8 wake pulse after reset");
    step(1'b1, 1'b0, N - 1,   0, 0, "R4 idle before refresh");
    step(1'b1, 1'b0, 1,       1, 0, "R5 refresh exactly N later");
    step(1'b1, 1'b1, 10,      0, 0, "R7 enable off");
    step(1'b0, 1'b1, 10,      0, 1, "R2 fall");

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].d, VECS[i].en, VECS[i].hold, VECS[i].sets, VECS[i].resets,
           $sformatf("vector %0d", i));
    end

    // Reset with a high input in low-power mode: nothing out of reset.
    do_reset(1'b1, 1'b1);
    step(1'b1, 1'b1, 40, 0, 0, "R9 no spurious edge out of reset");
    step(1'b1, 1'b0, 5,  1, 0, "R8 enable on carries level 1");

    check("R3 never both asserted", both_hits, 0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule